// File: doc/BRIEF.md
# Ten-Bit Word Demultiplexer with Self-Test Pattern Source

The block samples one 10-bit word on every rising clock edge and distributes consecutive words over up to eight output ports, A to H. In the 1:8 ratio one frame is eight clocks long and fills all eight ports. In the 1:4 ratio one frame is four clocks long, fills ports A to D, and holds ports E to H at zero. All ports of a frame change together at the end of the frame. A data-ready clock at the frame rate rises on that same edge, so a downstream receiver can capture on its leading edge.

A self-test request replaces the sampled input with a pseudo-random 10-bit code that advances once per clock. The source is a 9-bit shift register with one extra state that holds all zeros, so its period is exactly 512 clocks. A request is honoured only at a frame boundary. The first code therefore always lands on port A. Dropping the request returns the block to live input at the next frame boundary.

A four-state controller governs the source selection. In PASS, input words are passed through. In ARMED, a request has been seen mid-frame and is waiting for the boundary. In TEST, generator codes are driven. In LEAVING, the request has been dropped mid-frame and the generator keeps driving until the boundary. The transitions are:
- PASS→TEST on a request at a boundary edge.
- PASS→ARMED on a request at any other edge.
- ARMED→TEST at the boundary if the request is still high.
- ARMED→PASS when the request drops.
- TEST→PASS when the request is low at a boundary edge.
- TEST→LEAVING when the request is low at any other edge.
- LEAVING→TEST if the request returns. The generator continues without restarting.
- LEAVING→PASS at the boundary.

Top module: `frame_demux`

## Requirements
- R1: A synchronous reset puts the block in the following state after the next edge: slot 0, `drdy_o` low, all ports zero, controller in PASS. The ratio selected on `quad_sel_i` is latched during reset.
- R2: In the 1:8 ratio (`quad_sel_i`=0), the words sampled in slots 0..7 appear on ports A..H. Port A is `port_o[9:0]` and port H is `port_o[79:70]`. All eight ports update on the edge that samples the slot-7 word.
- R3: In the 1:4 ratio (`quad_sel_i`=1), the words sampled in slots 0..3 appear on ports A..D and update on the edge that samples slot 3. Ports E..H read zero.
- R4: `drdy_o` has a period equal to the frame length (8 or 4 clocks) and is high for half of it. It rises on the same edge as the port update.
- R5: A change of `quad_sel_i` takes effect only at a frame boundary. The running frame completes with its old length.
- R6: Generator codes follow this rule. The 9-bit state s becomes {s[7:0], s[8]^s[4]^(s[7:0]==0)} each clock. The code is {^s, s[7:0], s[8]}, so code bit 9 is the parity of s, code bits 8..1 are s[7:0], and code bit 0 is s[8]. The state is loaded with 9'h001 when a test run starts.
- R7: The code stream repeats with a period of exactly 512 clocks. Over one period, all 256 values of code bits 8..1 occur.
- R8: A request raised mid-frame is held until the next boundary. The first code, 10'h202, is placed on port A of a fresh frame.
- R9: Dropping the request mid-frame keeps codes flowing until the boundary. Input words are used from slot 0 of the next frame.
- R10: Between two rising edges of `drdy_o`, the ports do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Sampling clock |
| rst_i | input | 1 | Synchronous reset, active high |
| quad_sel_i | input | 1 | 0 selects 1:8, 1 selects 1:4 |
| bist_req_i | input | 1 | Self-test request, level sensitive |
| din_i | input | 10 | Input word, sampled every clock |
| port_o | output | 80 | Ports A..H, 10 bits each, A at bits 9:0 |
| drdy_o | output | 1 | Data-ready clock at the frame rate |

## Verification
A slot counter that is off by one shows on the ports within one frame. Words land on the wrong port, and the data-ready edge moves against the reference, which is compared every clock. A wrong controller state or a badly timed reload of the generator shows within one frame as a code in the wrong slot. A fault in the generator recurrence corrupts every following code. A subtle fault that keeps the codes plausible still breaks the 512-clock repeat or the 256-value coverage, which are checked over two full periods.

// File: rtl/fdx_pkg.sv
package fdx_pkg;

    // Source-selection controller states
    typedef enum logic [1:0] {
        BS_PASS  = 2'd0,
        BS_ARM   = 2'd1,
        BS_TEST  = 2'd2,
        BS_LEAVE = 2'd3
    } bist_state_e;

endpackage

// File: rtl/fdx_frame_ctl.sv
module fdx_frame_ctl #(
    parameter int NSLOT  = 8,
    parameter int SLOT_W = $clog2(NSLOT)
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              quad_req_i,
    output logic [SLOT_W-1:0] slot_o,
    output logic              boundary_o,
    output logic              quad_o,
    output logic              drdy_o
);

    localparam logic [SLOT_W-1:0] LAST_FULL = SLOT_W'(NSLOT - 1);
    localparam logic [SLOT_W-1:0] LAST_QUAD = SLOT_W'(NSLOT / 2 - 1);
    localparam logic [SLOT_W-1:0] MID_FULL  = SLOT_W'(NSLOT / 2 - 1);
    localparam logic [SLOT_W-1:0] MID_QUAD  = SLOT_W'(NSLOT / 4 - 1);

    logic [SLOT_W-1:0] slot_q;
    logic              quad_q;
    logic              drdy_q;
    logic [SLOT_W-1:0] last_slot;
    logic [SLOT_W-1:0] mid_slot;
    logic              at_end;

    always_comb begin
        last_slot = quad_q ? LAST_QUAD : LAST_FULL;
        mid_slot  = quad_q ? MID_QUAD  : MID_FULL;
        at_end    = (slot_q == last_slot);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            slot_q <= '0;
            quad_q <= quad_req_i;
            drdy_q <= 1'b0;
        end else begin
            slot_q <= at_end ? '0 : slot_q + 1'b1;
            if (at_end) begin
                quad_q <= quad_req_i;
            end
            if (at_end) begin
                drdy_q <= 1'b1;
            end else if (slot_q == mid_slot) begin
                drdy_q <= 1'b0;
            end
        end
    end

    assign slot_o     = slot_q;
    assign boundary_o = at_end;
    assign quad_o     = quad_q;
    assign drdy_o     = drdy_q;

endmodule

// File: rtl/fdx_prbs.sv
module fdx_prbs #(
    parameter int               GEN_W = 9,
    parameter int               TAP   = 5,
    parameter logic [GEN_W-1:0] SEED  = 9'h001
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             load_i,
    input  logic             step_i,
    output logic [GEN_W:0]   code_o,
    output logic [GEN_W-1:0] state_o
);

    logic [GEN_W-1:0] state_q;
    logic             fb;

    // Feedback with zero-state insertion: full 2^GEN_W cycle
    always_comb begin
        fb = state_q[GEN_W-1] ^ state_q[TAP-1] ^ ~|state_q[GEN_W-2:0];
    end

    always_ff @(posedge clk_i) begin
        if (rst_i || load_i) begin
            state_q <= SEED;
        end else if (step_i) begin
            state_q <= {state_q[GEN_W-2:0], fb};
        end
    end

    assign code_o  = {^state_q, state_q[GEN_W-2:0], state_q[GEN_W-1]};
    assign state_o = state_q;

endmodule

// File: rtl/fdx_bist_seq.sv
module fdx_bist_seq
    import fdx_pkg::*;
#(
    parameter int               WORD_W = 10,
    parameter int               GEN_W  = 9,
    parameter int               TAP    = 5,
    parameter logic [GEN_W-1:0] SEED   = 9'h001
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              req_i,
    input  logic              boundary_i,
    input  logic [WORD_W-1:0] din_i,
    output logic [WORD_W-1:0] word_o,
    output bist_state_e       state_o,
    output logic [GEN_W-1:0]  gen_o
);

    bist_state_e      state_q;
    bist_state_e      state_d;
    logic             use_code;
    logic             load_gen;
    logic [GEN_W:0]   code;

    // State register
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= BS_PASS;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BS_PASS: begin
                if (req_i) begin
                    state_d = boundary_i ? BS_TEST : BS_ARM;
                end
            end
            BS_ARM: begin
                if (!req_i) begin
                    state_d = BS_PASS;
                end else if (boundary_i) begin
                    state_d = BS_TEST;
                end
            end
            BS_TEST: begin
                if (!req_i) begin
                    state_d = boundary_i ? BS_PASS : BS_LEAVE;
                end
            end
            BS_LEAVE: begin
                if (req_i) begin
                    state_d = BS_TEST;
                end else if (boundary_i) begin
                    state_d = BS_PASS;
                end
            end
            default: state_d = BS_PASS;
        endcase
    end

    // Outputs
    always_comb begin
        use_code = (state_q == BS_TEST) || (state_q == BS_LEAVE);
        load_gen = (state_d == BS_TEST) &&
                   ((state_q == BS_PASS) || (state_q == BS_ARM));
        word_o   = use_code ? WORD_W'(code) : din_i;
    end

    fdx_prbs #(
        .GEN_W (GEN_W),
        .TAP   (TAP),
        .SEED  (SEED)
    ) u_prbs (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .load_i  (load_gen),
        .step_i  (use_code),
        .code_o  (code),
        .state_o (gen_o)
    );

    assign state_o = state_q;

endmodule

// File: rtl/fdx_port_bank.sv
module fdx_port_bank #(
    parameter int NPORT  = 8,
    parameter int WORD_W = 10,
    parameter int SLOT_W = $clog2(NPORT)
) (
    input  logic                    clk_i,
    input  logic                    rst_i,
    input  logic [SLOT_W-1:0]       slot_i,
    input  logic [WORD_W-1:0]       word_i,
    input  logic                    boundary_i,
    input  logic                    quad_i,
    output logic [NPORT*WORD_W-1:0] port_o
);

    for (genvar g = 0; g < NPORT; g++) begin : g_port
        localparam logic [SLOT_W-1:0] MY_SLOT = SLOT_W'(g);
        localparam bit                UPPER   = (g >= NPORT / 2);

        logic [WORD_W-1:0] shadow_q;
        logic [WORD_W-1:0] out_q;

        always_ff @(posedge clk_i) begin
            if (rst_i) begin
                shadow_q <= '0;
                out_q    <= '0;
            end else begin
                if (slot_i == MY_SLOT) begin
                    shadow_q <= word_i;
                end
                if (boundary_i) begin
                    if (UPPER && quad_i) begin
                        out_q <= '0;
                    end else begin
                        out_q <= (slot_i == MY_SLOT) ? word_i : shadow_q;
                    end
                end
            end
        end

        assign port_o[g*WORD_W +: WORD_W] = out_q;
    end

endmodule

// File: rtl/frame_demux.sv
module frame_demux
    import fdx_pkg::*;
#(
    parameter int               WORD_W   = 10,
    parameter int               NPORT    = 8,
    parameter int               GEN_W    = 9,
    parameter int               GEN_TAP  = 5,
    parameter logic [GEN_W-1:0] GEN_SEED = 9'h001
) (
    input  logic                    clk_i,
    input  logic                    rst_i,
    input  logic                    quad_sel_i,
    input  logic                    bist_req_i,
    input  logic [WORD_W-1:0]       din_i,
    output logic [NPORT*WORD_W-1:0] port_o,
    output logic                    drdy_o
);

    localparam int SLOT_W = $clog2(NPORT);

    logic [SLOT_W-1:0] slot;
    logic              boundary;
    logic              quad;
    logic [WORD_W-1:0] word;
    bist_state_e       bstate;
    logic [GEN_W-1:0]  gen_state;

    fdx_frame_ctl #(
        .NSLOT  (NPORT),
        .SLOT_W (SLOT_W)
    ) u_frame (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .quad_req_i (quad_sel_i),
        .slot_o     (slot),
        .boundary_o (boundary),
        .quad_o     (quad),
        .drdy_o     (drdy_o)
    );

    fdx_bist_seq #(
        .WORD_W (WORD_W),
        .GEN_W  (GEN_W),
        .TAP    (GEN_TAP),
        .SEED   (GEN_SEED)
    ) u_src (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .req_i      (bist_req_i),
        .boundary_i (boundary),
        .din_i      (din_i),
        .word_o     (word),
        .state_o    (bstate),
        .gen_o      (gen_state)
    );

    fdx_port_bank #(
        .NPORT  (NPORT),
        .WORD_W (WORD_W),
        .SLOT_W (SLOT_W)
    ) u_bank (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .slot_i     (slot),
        .word_i     (word),
        .boundary_i (boundary),
        .quad_i     (quad),
        .port_o     (port_o)
    );

endmodule

// File: rtl/frame_demux_chk.sv
module frame_demux_chk
    import fdx_pkg::*;
#(
    parameter int NPORT  = 8,
    parameter int WORD_W = 10,
    parameter int GEN_W  = 9,
    parameter int SLOT_W = $clog2(NPORT)
) (
    input logic                    clk_i,
    input logic                    rst_i,
    input logic [NPORT*WORD_W-1:0] port_o,
    input logic                    drdy_o,
    input logic [SLOT_W-1:0]       slot_i,
    input logic                    quad_i,
    input bist_state_e             bstate_i,
    input logic [GEN_W-1:0]        gen_i
);

    localparam logic [SLOT_W-1:0] HALF_FULL = SLOT_W'(NPORT / 2);
    localparam logic [SLOT_W-1:0] HALF_QUAD = SLOT_W'(NPORT / 4);
    localparam logic [SLOT_W-1:0] LAST_QUAD = SLOT_W'(NPORT / 2 - 1);

    AST_RESET_QUIET: assert property (@(posedge clk_i)
        rst_i |=> (!drdy_o && (port_o == '0))) else $error("reset state"); // R1

    AST_PORTS_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        !$rose(drdy_o) |-> $stable(port_o)) else $error("ports moved"); // R10

    AST_QUAD_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
        ($rose(drdy_o) && $past(quad_i)) |->
            (port_o[NPORT*WORD_W-1:(NPORT/2)*WORD_W] == '0)) else $error("upper ports"); // R3

    AST_DRDY_FIRST_HALF: assert property (@(posedge clk_i) disable iff (rst_i)
        drdy_o |-> (slot_i < (quad_i ? HALF_QUAD : HALF_FULL))) else $error("drdy phase"); // R4

    AST_QUAD_SLOT_RANGE: assert property (@(posedge clk_i) disable iff (rst_i)
        quad_i |-> (slot_i <= LAST_QUAD)) else $error("slot range"); // R5

    AST_TEST_STARTS_SLOT0: assert property (@(posedge clk_i) disable iff (rst_i)
        ((bstate_i == BS_TEST) &&
         (($past(bstate_i) == BS_PASS) || ($past(bstate_i) == BS_ARM)))
            |-> (slot_i == '0)) else $error("test start phase"); // R8

    AST_PASS_RESUMES_SLOT0: assert property (@(posedge clk_i) disable iff (rst_i)
        ((bstate_i == BS_PASS) &&
         (($past(bstate_i) == BS_TEST) || ($past(bstate_i) == BS_LEAVE)))
            |-> (slot_i == '0)) else $error("pass resume phase"); // R9

    AST_GEN_ADVANCES: assert property (@(posedge clk_i) disable iff (rst_i)
        (((bstate_i == BS_TEST) || (bstate_i == BS_LEAVE)) &&
         (($past(bstate_i) == BS_TEST) || ($past(bstate_i) == BS_LEAVE)))
            |-> (gen_i != $past(gen_i))) else $error("generator stuck"); // R6

endmodule

bind frame_demux frame_demux_chk #(
    .NPORT  (NPORT),
    .WORD_W (WORD_W),
    .GEN_W  (GEN_W)
) u_chk (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .port_o   (port_o),
    .drdy_o   (drdy_o),
    .slot_i   (slot),
    .quad_i   (quad),
    .bstate_i (bstate),
    .gen_i    (gen_state)
);

// File: tb/frame_demux_tb.sv
`timescale 1ns/1ps
module frame_demux_tb;

    localparam int W    = 10;
    localparam int N    = 8;
    localparam int SEED = 1;

    logic           clk = 1'b0;
    logic           rst;
    logic           quad_sel;
    logic           bist_req;
    logic [W-1:0]   din;
    logic [N*W-1:0] port;
    logic           drdy;

    always #2.5 clk = ~clk;

    frame_demux u_dut (
        .clk_i      (clk),
        .rst_i      (rst),
        .quad_sel_i (quad_sel),
        .bist_req_i (bist_req),
        .din_i      (din),
        .port_o     (port),
        .drdy_o     (drdy)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    int    cyc   = 0;
    string cur_req = "R1";
    bit    started = 0;
    bit    done = 0;

    // reference model state
    int m_slot, m_quad, m_drdy, m_bst, m_g;
    int m_fr[N];
    int m_port[N];
    int m_last, m_mid, m_w, m_nb;
    bit m_bnd;

    // collection of codes seen on the ports
    bit want_collect = 0;
    int pend = 0;
    int prev_drdy = 0;
    int seen[$];

    function automatic int ref_next(int s);
        int fb;
        fb = ((s >> 8) & 1) ^ ((s >> 4) & 1) ^ (((s & 255) == 0) ? 1 : 0);
        return ((s << 1) & 511) | fb;
    endfunction

    function automatic int ref_code(int s);
        int par = 0;
        for (int i = 0; i < 9; i++) par ^= (s >> i) & 1;
        return (par << 9) | ((s & 255) << 1) | ((s >> 8) & 1);
    endfunction

    task automatic check(bit ok, string req, int act, int exp, string what);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // behavioural reference, sampled at the same edge as the design
    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            m_slot = 0; m_quad = quad_sel; m_drdy = 0; m_bst = 0; m_g = SEED;
            for (int p = 0; p < N; p++) begin m_port[p] = 0; m_fr[p] = 0; end
        end else begin
            m_last = m_quad ? 3 : 7;
            m_mid  = m_quad ? 1 : 3;
            m_w    = (m_bst >= 2) ? ref_code(m_g) : int'(din);
            m_fr[m_slot] = m_w;
            m_bnd  = (m_slot == m_last);
            if (m_bnd) begin
                for (int p = 0; p < N; p++) m_port[p] = (m_quad != 0 && p >= 4) ? 0 : m_fr[p];
                m_drdy = 1;
            end else if (m_slot == m_mid) begin
                m_drdy = 0;
            end
            case (m_bst)
                0: m_nb = bist_req ? (m_bnd ? 2 : 1) : 0;
                1: m_nb = !bist_req ? 0 : (m_bnd ? 2 : 1);
                2: m_nb = bist_req ? 2 : (m_bnd ? 0 : 3);
                default: m_nb = bist_req ? 2 : (m_bnd ? 0 : 3);
            endcase
            if (m_bst >= 2) m_g = ref_next(m_g);
            if (m_nb == 2 && m_bst < 2) begin
                m_g = SEED;
                if (want_collect) pend = 1;
            end
            m_bst  = m_nb;
            m_slot = m_bnd ? 0 : m_slot + 1;
            if (m_bnd) m_quad = quad_sel;
        end
        started = 1;
    end

    // per-clock comparison, away from the active edge
    always @(negedge clk) begin
        if (started && !done) begin
            bit ok;
            ok = (int'(drdy) == m_drdy);
            for (int p = 0; p < N; p++) ok &= (int'(port[p*W +: W]) == m_port[p]);
            check(ok, cur_req, {drdy, port[15:0]}, {m_drdy[0], m_port[1][5:0], m_port[0][9:0]},
                  "drdy/ports vs reference");
            if (drdy && prev_drdy == 0) begin
                if (pend == 1) pend = 2;
                else if (pend == 2) for (int p = 0; p < N; p++) seen.push_back(int'(port[p*W +: W]));
            end
            prev_drdy = drdy;
        end
    end

    // watchdog
    always @(posedge clk) begin
        if (cyc > 20000) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual %0d expected <= 20000 cycles", cyc);
            finish_run();
        end
    end

    task automatic run(int n, int kind);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            case (kind)
                0: din = W'(i * 37 + 5);
                1: din = (i[0]) ? 10'h2AA : 10'h155;
                default: din = W'(1 << (i % W));
            endcase
        end
    endtask

    initial begin
        rst = 1'b1; quad_sel = 1'b0; bist_req = 1'b0; din = '0;
        repeat (3) @(negedge clk);
        check(drdy == 1'b0, "R1", drdy, 0, "drdy in reset");
        check(port == '0, "R1", int'(port[W-1:0]), 0, "ports in reset");
        rst = 1'b0;

        cur_req = "R2";  run(48, 0);
        cur_req = "R4";  run(27, 1);
        cur_req = "R5";  quad_sel = 1'b1; run(13, 0);
        cur_req = "R3";  run(32, 2);
        cur_req = "R5";  quad_sel = 1'b0; run(3, 1);
        cur_req = "R10"; run(30, 0);

        cur_req = "R8"; want_collect = 1; run(3, 0); bist_req = 1'b1;
        run(24, 2);
        cur_req = "R6"; run(1100, 0);
        want_collect = 0; pend = 0;
        check(seen.size() >= 1024, "R7", seen.size(), 1024, "codes collected");
        if (seen.size() >= 1024) begin
            bit hit[256];
            int missing = 0;
            int rep_bad = 0;
            check(seen[0] == ref_code(SEED), "R8", seen[0], ref_code(SEED), "first code on port A");
            check(seen[1] == ref_code(ref_next(SEED)), "R6", seen[1], ref_code(ref_next(SEED)), "second code on port B");
            for (int i = 0; i < 256; i++) hit[i] = 0;
            for (int i = 0; i < 512; i++) begin
                hit[(seen[i] >> 1) & 255] = 1;
                if (seen[i] != seen[i + 512]) rep_bad++;
            end
            for (int i = 0; i < 256; i++) if (!hit[i]) missing++;
            check(rep_bad == 0, "R7", rep_bad, 0, "codes differing after 512 clocks");
            check(missing == 0, "R7", missing, 0, "middle-byte values missing");
            check(seen[1] != seen[0], "R7", seen[1], seen[0], "adjacent codes differ");
        end

        cur_req = "R9"; run(5, 0); bist_req = 1'b0; run(30, 0);
        cur_req = "R6"; quad_sel = 1'b1; run(2, 0); bist_req = 1'b1; run(80, 1);
        cur_req = "R9"; run(1, 0); bist_req = 1'b0; run(24, 2);
        cur_req = "R3"; run(16, 0);

        cur_req = "R1"; rst = 1'b1; run(2, 0);
        check(drdy == 1'b0, "R1", drdy, 0, "drdy after mid-run reset");
        check(port == '0, "R1", int'(port[W-1:0]), 0, "ports after mid-run reset");
        rst = 1'b0; quad_sel = 1'b0;
        cur_req = "R2"; run(24, 2);

        done = 1;
        finish_run();
    end

endmodule